// File: doc/BRIEF.md
# Bidirectional Latch-Register Bus Transceiver

This block carries a parameterised data word (17 bits by default) between an A bus and a B bus, one data path per direction. Each path keeps its own storage. Depending on its controls, that storage acts as a transparent latch, as a hold latch, or as an edge-triggered register whose port clock can be gated off. Each direction has four controls: an output enable (active low), a latch enable, a port clock and a clock enable (active low). The block supplies output data and a drive-enable for each bus. The enclosing level builds the tri-state pins from these.

All logic runs on one fast system clock. Each port clock is treated as an asynchronous input: it passes through a two-flop synchronizer, and its rising edges are detected on the system clock. The two directions may never drive at the same time. When both output enables are asserted together, the block withdraws both drive-enables and raises a sticky conflict flag, which only reset clears.

Top module: `bus_xcvr_lr`

## Requirements
- R1: Both paths are W bits wide (default 17, bit 16 is the MSB). The A-to-B path (A input to B output) and the B-to-A path work the same way and do not affect each other.
- R2: While a path's output enable `*_oe_ni` is 1, its drive-enable output is 0 (isolation).
- R3: While a path's `*_oe_ni` is 0, the other path's is 1 and no conflict is latched, its drive-enable output is 1 in the same cycle.
- R4: While a path's latch enable `*_le_i` is 1, its data output equals its data input in the same cycle (transparent).
- R5: Storage loads the input on every system-clock edge at which latch enable is 1. After latch enable falls, the output holds the input from the last cycle in which latch enable was 1.
- R6: With latch enable 0 and clock enable `*_ce_ni` 0, a 0-to-1 transition of the port clock captures the input. The output shows the captured value from the third system-clock edge after the port clock rises.
- R7: With latch enable 0, clock enable 0 and the port clock held steady, the output keeps its stored value while the input changes.
- R8: With clock enable 1 and latch enable 0, port-clock edges are ignored and the output keeps its stored value.
- R9: In any cycle in which both `*_oe_ni` are 0, both drive-enables are 0 in that same cycle, and `conflict_o` is 1 from the next cycle.
- R10: Once set, `conflict_o` stays 1 and both drive-enables stay 0 until reset, whatever the output enables do.
- R11: Reset (`rst_ni` low) clears `conflict_o` and zeroes both storage registers, so with latch enable 0 both data outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_data_i | input | W | A bus input data |
| b_data_i | input | W | B bus input data |
| ab_oe_ni | input | 1 | A-to-B output enable, active low |
| ab_le_i | input | 1 | A-to-B latch enable |
| ab_clk_i | input | 1 | A-to-B port clock (asynchronous) |
| ab_ce_ni | input | 1 | A-to-B clock enable, active low |
| ba_oe_ni | input | 1 | B-to-A output enable, active low |
| ba_le_i | input | 1 | B-to-A latch enable |
| ba_clk_i | input | 1 | B-to-A port clock (asynchronous) |
| ba_ce_ni | input | 1 | B-to-A clock enable, active low |
| b_data_o | output | W | Data toward the B bus |
| b_drv_o | output | 1 | Drive-enable for the B bus pins |
| a_data_o | output | W | Data toward the A bus |
| a_drv_o | output | 1 | Drive-enable for the A bus pins |
| conflict_o | output | 1 | Sticky flag: both output enables were asserted together |

## Verification
A corrupted storage register does not show while latch enable is high, because the output then follows the input. It shows in the first cycle after latch enable falls, as a data output that differs from the last transparent word. A capture that is missed or spurious shows as a wrong held value three system cycles after a port-clock rise, or after an ignored edge under clock inhibit. Every held-value check therefore changes the input while the hold is in force. A conflict guard that is broken shows in the same cycle as a drive-enable that stays high, or one cycle later as a missing or non-sticky flag.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned DIRS = 2;

  typedef enum logic {
    DIR_AB = 1'b0,
    DIR_BA = 1'b1
  } dir_e;

  typedef struct packed {
    logic oe_n;
    logic le;
    logic pclk;
    logic ce_n;
  } lane_ctrl_t;
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  // sh[STAGES-1] is the synchronized sample, sh[STAGES] the previous one
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
  parameter int unsigned W = 17
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] din_i,
  input  logic         le_i,
  input  logic         rise_i,
  input  logic         ce_ni,
  output logic [W-1:0] dout_o
);
  logic [W-1:0] store_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                store_q <= '0;
    else if (le_i)              store_q <= din_i;   // track while transparent
    else if (rise_i && !ce_ni)  store_q <= din_i;   // clocked capture
  end

  assign dout_o = le_i ? din_i : store_q;
endmodule

// File: rtl/conflict_guard.sv
module conflict_guard #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] oe_ni,
  output logic [N-1:0] drv_o,
  output logic         err_o
);
  logic [N-1:0] on;
  logic         clash;
  logic         err_q;

  assign on    = ~oe_ni;
  assign clash = ($countones(on) > 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    err_q <= 1'b0;
    else if (clash) err_q <= 1'b1;
  end

  assign drv_o = on & {N{~clash & ~err_q}};
  assign err_o = err_q;
endmodule

// File: rtl/bus_xcvr_lr.sv
module bus_xcvr_lr
  import xcvr_pkg::*;
#(
  parameter int unsigned W           = 17,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_data_i,
  input  logic [W-1:0] b_data_i,
  input  logic         ab_oe_ni,
  input  logic         ab_le_i,
  input  logic         ab_clk_i,
  input  logic         ab_ce_ni,
  input  logic         ba_oe_ni,
  input  logic         ba_le_i,
  input  logic         ba_clk_i,
  input  logic         ba_ce_ni,
  output logic [W-1:0] b_data_o,
  output logic         b_drv_o,
  output logic [W-1:0] a_data_o,
  output logic         a_drv_o,
  output logic         conflict_o
);
  lane_ctrl_t          ctrl [DIRS];
  logic [W-1:0]        din  [DIRS];
  logic [W-1:0]        dout [DIRS];
  logic [DIRS-1:0]     rise;
  logic [DIRS-1:0]     oe_n;
  logic [DIRS-1:0]     drv;

  assign ctrl[DIR_AB] = '{oe_n: ab_oe_ni, le: ab_le_i, pclk: ab_clk_i, ce_n: ab_ce_ni};
  assign ctrl[DIR_BA] = '{oe_n: ba_oe_ni, le: ba_le_i, pclk: ba_clk_i, ce_n: ba_ce_ni};
  assign din[DIR_AB]  = a_data_i;
  assign din[DIR_BA]  = b_data_i;

  for (genvar d = 0; d < DIRS; d++) begin : g_dir
    edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .async_i(ctrl[d].pclk),
      .rise_o (rise[d])
    );

    xcvr_lane #(.W(W)) u_lane (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .din_i (din[d]),
      .le_i  (ctrl[d].le),
      .rise_i(rise[d]),
      .ce_ni (ctrl[d].ce_n),
      .dout_o(dout[d])
    );

    assign oe_n[d] = ctrl[d].oe_n;
  end

  conflict_guard #(.N(DIRS)) u_guard (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .oe_ni (oe_n),
    .drv_o (drv),
    .err_o (conflict_o)
  );

  assign b_data_o = dout[DIR_AB];
  assign a_data_o = dout[DIR_BA];
  assign b_drv_o  = drv[DIR_AB];
  assign a_drv_o  = drv[DIR_BA];
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
  parameter int unsigned W = 17
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] a_data_i,
  input logic [W-1:0] b_data_i,
  input logic         ab_oe_ni,
  input logic         ab_le_i,
  input logic         ab_ce_ni,
  input logic         ba_oe_ni,
  input logic         ba_le_i,
  input logic         ba_ce_ni,
  input logic [W-1:0] b_data_o,
  input logic         b_drv_o,
  input logic [W-1:0] a_data_o,
  input logic         a_drv_o,
  input logic         conflict_o
);
  a_r2_ab_isolate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ab_oe_ni |-> !b_drv_o);
  a_r2_ba_isolate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ba_oe_ni |-> !a_drv_o);

  a_r3_ab_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ab_oe_ni && ba_oe_ni && !conflict_o) |-> b_drv_o);

  a_r4_ab_transp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ab_le_i |-> (b_data_o == a_data_i));
  a_r4_ba_transp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ba_le_i |-> (a_data_o == b_data_i));

  a_r5_ab_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ab_le_i |=> (ab_le_i || b_data_o == $past(a_data_i)));

  a_r8_ab_inhibit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ab_le_i && ab_ce_ni) |=> (ab_le_i || b_data_o == $past(b_data_o)));
  a_r8_ba_inhibit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ba_le_i && ba_ce_ni) |=> (ba_le_i || a_data_o == $past(a_data_o)));

  a_r9_clash_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ab_oe_ni && !ba_oe_ni) |-> (!a_drv_o && !b_drv_o));
  a_r9_clash_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ab_oe_ni && !ba_oe_ni) |=> conflict_o);

  a_r10_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conflict_o |=> conflict_o);
  a_r10_muted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conflict_o |-> (!a_drv_o && !b_drv_o));
endmodule

bind bus_xcvr_lr xcvr_chk #(.W(W)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .a_data_i  (a_data_i),
  .b_data_i  (b_data_i),
  .ab_oe_ni  (ab_oe_ni),
  .ab_le_i   (ab_le_i),
  .ab_ce_ni  (ab_ce_ni),
  .ba_oe_ni  (ba_oe_ni),
  .ba_le_i   (ba_le_i),
  .ba_ce_ni  (ba_ce_ni),
  .b_data_o  (b_data_o),
  .b_drv_o   (b_drv_o),
  .a_data_o  (a_data_o),
  .a_drv_o   (a_drv_o),
  .conflict_o(conflict_o)
);

// File: tb/bus_xcvr_lr_tb_top.sv
module bus_xcvr_lr_tb_top;
  localparam int unsigned W      = 17;
  localparam time         CLK_PD = 10ns;
  localparam int unsigned NPAT   = W + 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a_d = '0, b_d = '0;
  logic         ab_oe_n = 1'b1, ab_le = 1'b0, ab_clk = 1'b0, ab_ce_n = 1'b1;
  logic         ba_oe_n = 1'b1, ba_le = 1'b0, ba_clk = 1'b0, ba_ce_n = 1'b1;
  logic [W-1:0] b_q, a_q;
  logic         b_drv, a_drv, conflict;

  int errors = 0;
  int checks = 0;

  always #(CLK_PD/2) clk = ~clk;

  bus_xcvr_lr #(.W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .a_data_i(a_d), .b_data_i(b_d),
    .ab_oe_ni(ab_oe_n), .ab_le_i(ab_le), .ab_clk_i(ab_clk), .ab_ce_ni(ab_ce_n),
    .ba_oe_ni(ba_oe_n), .ba_le_i(ba_le), .ba_clk_i(ba_clk), .ba_ce_ni(ba_ce_n),
    .b_data_o(b_q), .b_drv_o(b_drv), .a_data_o(a_q), .a_drv_o(a_drv),
    .conflict_o(conflict)
  );

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic set_src(int d, logic [W-1:0] v);
    if (d == 0) a_d = v; else b_d = v;
  endtask

  task automatic set_ctl(int d, logic oe_n, logic le, logic pc, logic ce_n);
    if (d == 0) begin ab_oe_n = oe_n; ab_le = le; ab_clk = pc; ab_ce_n = ce_n; end
    else        begin ba_oe_n = oe_n; ba_le = le; ba_clk = pc; ba_ce_n = ce_n; end
  endtask

  function automatic logic [W-1:0] out_of(int d);
    return (d == 0) ? b_q : a_q;
  endfunction

  function automatic logic drv_of(int d);
    return (d == 0) ? b_drv : a_drv;
  endfunction

  function automatic logic [W-1:0] pat(int i);
    if (i < W) return W'(1) << i;
    case (i - W)
      0:       return {W{1'b1}};
      1:       return {(W+1)/2{2'b10}};
      default: return {(W+1)/2{2'b01}};
    endcase
  endfunction

  task automatic sweep(int d);
    logic [W-1:0] p, p2;
    set_ctl(d, 1'b1, 1'b0, 1'b0, 1'b1);
    #1 chk("R2 isolation", W'(drv_of(d)), W'(0));
    set_ctl(d, 1'b0, 1'b0, 1'b0, 1'b1);
    #1 chk("R3 drive", W'(drv_of(d)), W'(1));
    for (int i = 0; i < NPAT; i++) begin
      p  = pat(i);
      p2 = p ^ {W{1'b1}} ^ W'(i * 5);
      @(negedge clk);
      set_ctl(d, 1'b0, 1'b1, 1'b0, 1'b1);
      set_src(d, p);
      #1 chk((i == W-1) ? "R1 msb transparent" : "R4 transparent", out_of(d), p);
      @(negedge clk);
      set_ctl(d, 1'b0, 1'b0, 1'b0, 1'b0);
      set_src(d, ~p);
      #1 chk("R5 freeze", out_of(d), p);
      cyc(3);
      chk("R7 steady clock", out_of(d), p);
      set_src(d, p2);
      set_ctl(d, 1'b0, 1'b0, 1'b1, 1'b0);
      cyc(2);
      chk("R6 before capture", out_of(d), p);
      cyc(2);
      chk("R6 capture", out_of(d), p2);
      set_ctl(d, 1'b0, 1'b0, 1'b0, 1'b1);
      set_src(d, ~p2);
      cyc(4);
      set_ctl(d, 1'b0, 1'b0, 1'b1, 1'b1);
      cyc(4);
      set_ctl(d, 1'b0, 1'b0, 1'b0, 1'b1);
      cyc(4);
      chk("R8 inhibit", out_of(d), p2);
    end
    set_ctl(d, 1'b1, 1'b0, 1'b0, 1'b1);
    #1;
  endtask

  initial begin
    #(CLK_PD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(2);
    chk("R11 reset b out", b_q, '0);
    chk("R11 reset a out", a_q, '0);
    chk("R11 reset flag", W'(conflict), W'(0));
    rst_n = 1'b1;
    cyc(2);
    chk("R11 post reset flag", W'(conflict), W'(0));

    sweep(0);
    chk("R1 B-to-A untouched", a_q, '0);
    sweep(1);
    chk("R1 A-to-B held", b_q, pat(NPAT-1) ^ {W{1'b1}} ^ W'((NPAT-1) * 5));

    @(negedge clk);
    ab_oe_n = 1'b0; ba_oe_n = 1'b0;
    #1 chk("R9 both off b", W'(b_drv), W'(0));
    chk("R9 both off a", W'(a_drv), W'(0));
    chk("R9 flag not yet", W'(conflict), W'(0));
    cyc(1);
    chk("R9 flag set", W'(conflict), W'(1));
    ab_oe_n = 1'b1;
    #1 chk("R10 a stays off", W'(a_drv), W'(0));
    cyc(5);
    chk("R10 flag sticky", W'(conflict), W'(1));
    chk("R10 a still off", W'(a_drv), W'(0));

    rst_n = 1'b0;
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
    chk("R11 flag cleared", W'(conflict), W'(0));
    chk("R11 b store zero", b_q, '0);
    chk("R11 a store zero", a_q, '0);
    chk("R11 a drive back", W'(a_drv), W'(1));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule